// File: doc/BRIEF.md
# Retire-Point Add Conformance Monitor

This block is a synthesizable monitor placed beside a small in-order pipeline with five stages (fetch, decode, execute, memory, write-back) that uses forwarding. Operands are read when an instruction moves from decode into execute. Results are written when it moves from memory into write-back. Each fetched 16-bit opcode is copied down a shadow chain of slots for the decode, execute and memory stages. Each slot obeys the same stall and flush controls as its datapath stage. The opcode is therefore still known at the point where the instruction commits.

The instruction in the memory slot commits in the cycle it leaves that slot. In that cycle the pipeline presents two views of its eight 32-bit registers: the state before the instruction, as held at the end of write-back, and the state after it, as produced at the end of memory. The pipeline is never drained around the checked instruction, so forwarding and hazards from earlier instructions stay in play. If the committing opcode is a register-register add, the monitor computes the expected sum combinationally and compares it with the destination register in the after-state. One cycle later it raises a single-cycle mismatch pulse. A sticky error flag also records that a mismatch has occurred.

Top module: `conf_monitor`

## Requirements
- R1: While `rst_n` is low, and at the first sample after reset, `mismatch_o` and `error_o` are 0 and every shadow slot is empty.
- R2: An opcode counts as an add only when `(op & 16'hFE00) == 16'h1800`. No other committed opcode ever raises `mismatch_o`, whatever the register views hold.
- R3: For an add, source A is `op[8:6]`, source B is `op[5:3]` and the destination is `op[2:0]`. A mismatch is raised exactly when `post[op[2:0]] != pre[op[8:6]] + pre[op[5:3]]`. Register n sits at bits `[32n+31:32n]` of `rf_pre_i` and `rf_post_i`. Other registers of the after-state are not compared.
- R4: The sum is taken modulo 2^32.
- R5: An instruction accepted at a clock edge with no stalls or flushes commits in the cycle after the second following edge. `mismatch_o` then shows the verdict after the third edge following acceptance. The pulse lasts one cycle per committing add, so back-to-back failing adds give pulses on consecutive cycles.
- R6: A slot whose stall is high and whose flush is low keeps its content. A stalled memory slot does not commit, and an instruction stalled there for several cycles is checked exactly once.
- R7: When a slot advances while the slot before it is stalled, it receives an empty entry, so no instruction is duplicated. A fetch with `fetch_valid_i` low enters as an empty entry.
- R8: A high flush on a slot empties it at the next edge, taking precedence over stall. A flushed instruction does not move on and is never checked. A flushed memory slot does not commit.
- R9: `error_o` becomes 1 together with the first `mismatch_o` pulse and stays 1 until reset.
- R10: Reset empties every slot, so an instruction that was in flight when reset was asserted never raises `mismatch_o` or `error_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_valid_i | input | 1 | Fetched opcode is a real instruction |
| fetch_op_i | input | 16 | Fetched opcode |
| stall_i | input | NSLOT (3) | Stall per slot: bit 0 decode, bit 1 execute, bit 2 memory |
| flush_i | input | NSLOT (3) | Flush per slot, same bit order as `stall_i` |
| rf_pre_i | input | 8*XLEN (256) | Register file before the committing instruction, register n at bits [32n+31:32n] |
| rf_post_i | input | 8*XLEN (256) | Register file after the committing instruction, same layout |
| mismatch_o | output | 1 | Registered pulse: the committed add disagrees with the formula |
| error_o | output | 1 | Sticky flag: a mismatch has occurred since reset |

## Verification
The bench targets the corner cases where a shadow chain can drift out of step with the datapath. An instruction held in the memory slot must be checked exactly once; a design that ignored the stall would flag it early or more than once. A stalled decode slot must not feed copies of its instruction downstream; a design that skipped the bubble would raise duplicate pulses. An add flushed in execute, or flushed while also stalled in memory, must never be checked; a design that ignored the flush, or let stall win, would report a phantom mismatch. The bench also drives a wrapping sum, equal source indices, a wrong value in a register other than the destination, near-miss opcodes and an add in flight across reset. A design with a bad decode mask, swapped fields, wide arithmetic or an incomplete reset would flag some of these cases wrongly.

// File: rtl/cmon_pkg.sv
// Package: shared constants and the add decoder for the conformance monitor.
// Assumes 16-bit opcodes and an eight-entry register file with 3-bit indices.
package cmon_pkg;
    localparam int OP_W  = 16;
    localparam int IDX_W = 3;
    localparam int NREG  = 1 << IDX_W;
    localparam logic [OP_W-1:0] ADD_MASK  = 16'hFE00;
    localparam logic [OP_W-1:0] ADD_MATCH = 16'h1800;

    typedef struct packed {
        logic             is_add;
        logic [IDX_W-1:0] src_a;
        logic [IDX_W-1:0] src_b;
        logic [IDX_W-1:0] dst;
    } add_fields_t;

    // Split an opcode into its add recognition bit and register indices.
    function automatic add_fields_t decode_add(input logic [OP_W-1:0] op);
        add_fields_t f;
        f.is_add = ((op & ADD_MASK) == ADD_MATCH);
        f.src_a  = op[8:6];
        f.src_b  = op[5:3];
        f.dst    = op[2:0];
        return f;
    endfunction
endpackage

// File: rtl/cmon_slot.sv
// Module: one shadow slot of the opcode chain.
// It mirrors one pipeline stage register. Flush empties the slot, stall holds it,
// and otherwise it takes the upstream entry. The upstream entry becomes a
// bubble when upstream is stalled (it stays behind) or flushed (it is killed).
// Assumes stall and flush follow the same meaning as the datapath stage.
module cmon_slot
    import cmon_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stall,
    input  logic            flush,
    input  logic            up_valid,
    input  logic [OP_W-1:0] up_op,
    input  logic            up_stall,
    input  logic            up_flush,
    output logic            valid,
    output logic [OP_W-1:0] op
);
    logic take_valid;

    // Decide whether the entry offered from upstream is a real instruction.
    always_comb begin
        take_valid = up_valid && !up_stall && !up_flush;
    end

    // Update the slot: reset, then flush, then stall, then advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            op    <= '0;
        end else if (flush) begin
            valid <= 1'b0;
        end else if (!stall) begin
            valid <= take_valid;
            op    <= up_op;
        end
    end
endmodule

// File: rtl/cmon_add_ref.sv
// Module: combinational reference for the register-register add.
// It decodes the committing opcode, sums the two before-state sources modulo
// 2^XLEN and compares the sum with the after-state destination register.
// Assumes registers are packed with register n at bits [XLEN*n +: XLEN].
module cmon_add_ref
    import cmon_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [OP_W-1:0]      op,
    input  logic [NREG*XLEN-1:0] rf_pre,
    input  logic [NREG*XLEN-1:0] rf_post,
    output logic                 is_add,
    output logic                 fail
);
    add_fields_t     f;
    logic [XLEN-1:0] opnd_a;
    logic [XLEN-1:0] opnd_b;
    logic [XLEN-1:0] expect_v;
    logic [XLEN-1:0] got_v;

    // Pick the operands and the destination, then form the verdict.
    always_comb begin
        f        = decode_add(op);
        opnd_a   = rf_pre[int'(f.src_a)*XLEN +: XLEN];
        opnd_b   = rf_pre[int'(f.src_b)*XLEN +: XLEN];
        got_v    = rf_post[int'(f.dst)*XLEN +: XLEN];
        expect_v = opnd_a + opnd_b;
        is_add   = f.is_add;
        fail     = f.is_add && (got_v != expect_v);
    end
endmodule

// File: rtl/cmon_verdict.sv
// Module: registers the check result as a one-cycle pulse and a sticky flag.
// Assumes check_en is high only in a commit cycle whose slot holds an add.
module cmon_verdict (
    input  logic clk,
    input  logic rst_n,
    input  logic check_en,
    input  logic fail,
    output logic mismatch_o,
    output logic error_o
);
    logic hit;

    // Combine the commit qualifier with the reference verdict.
    always_comb begin
        hit = check_en && fail;
    end

    // Register the pulse and accumulate the sticky flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mismatch_o <= 1'b0;
            error_o    <= 1'b0;
        end else begin
            mismatch_o <= hit;
            error_o    <= error_o | hit;
        end
    end
endmodule

// File: rtl/conf_monitor.sv
// Module: retire-point conformance monitor for a register-register add.
// A chain of NSLOT shadow slots (decode, execute, memory) carries opcodes under
// the pipeline's own stall and flush controls. The last slot commits when it is
// valid, not stalled and not flushed. In that cycle the pipeline supplies the
// before and after register views, and the add reference judges the result.
// Assumes rf_pre_i/rf_post_i are meaningful in every commit cycle.
module conf_monitor
    import cmon_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int NSLOT = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fetch_valid_i,
    input  logic [OP_W-1:0]      fetch_op_i,
    input  logic [NSLOT-1:0]     stall_i,
    input  logic [NSLOT-1:0]     flush_i,
    input  logic [NREG*XLEN-1:0] rf_pre_i,
    input  logic [NREG*XLEN-1:0] rf_post_i,
    output logic                 mismatch_o,
    output logic                 error_o
);
    localparam int LAST = NSLOT - 1;

    logic [NSLOT-1:0]           slot_valid;
    logic [NSLOT-1:0][OP_W-1:0] slot_op;
    logic                       commit;
    logic                       ref_is_add;
    logic                       ref_fail;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        if (k == 0) begin : g_head
            cmon_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .stall    (stall_i[k]),
                .flush    (flush_i[k]),
                .up_valid (fetch_valid_i),
                .up_op    (fetch_op_i),
                .up_stall (1'b0),
                .up_flush (1'b0),
                .valid    (slot_valid[k]),
                .op       (slot_op[k])
            );
        end else begin : g_body
            cmon_slot u_slot (
                .clk      (clk),
                .rst_n    (rst_n),
                .stall    (stall_i[k]),
                .flush    (flush_i[k]),
                .up_valid (slot_valid[k-1]),
                .up_op    (slot_op[k-1]),
                .up_stall (stall_i[k-1]),
                .up_flush (flush_i[k-1]),
                .valid    (slot_valid[k]),
                .op       (slot_op[k])
            );
        end
    end

    // The last slot commits when it leaves the memory stage this cycle.
    always_comb begin
        commit = slot_valid[LAST] && !stall_i[LAST] && !flush_i[LAST];
    end

    cmon_add_ref #(.XLEN(XLEN)) u_ref (
        .op      (slot_op[LAST]),
        .rf_pre  (rf_pre_i),
        .rf_post (rf_post_i),
        .is_add  (ref_is_add),
        .fail    (ref_fail)
    );

    cmon_verdict u_verdict (
        .clk        (clk),
        .rst_n      (rst_n),
        .check_en   (commit && ref_is_add),
        .fail       (ref_fail),
        .mismatch_o (mismatch_o),
        .error_o    (error_o)
    );
endmodule

// File: rtl/conf_monitor_chk.sv
// Module: assertion checker bound to conf_monitor.
// It relates the control ports to the shadow slots and to the registered outputs.
module conf_monitor_chk
    import cmon_pkg::*;
#(
    parameter int NSLOT = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [NSLOT-1:0]           stall_i,
    input logic [NSLOT-1:0]           flush_i,
    input logic [NSLOT-1:0]           slot_valid,
    input logic [NSLOT-1:0][OP_W-1:0] slot_op,
    input logic                       mismatch_o,
    input logic                       error_o
);
    localparam int LAST = NSLOT - 1;

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot_props
        // R6: a stalled, unflushed slot keeps its content
        assert_slot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stall_i[k] && !flush_i[k]) |=> ($stable(slot_valid[k]) && $stable(slot_op[k])));
        // R8: a flushed slot is empty afterwards
        assert_slot_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
            flush_i[k] |=> !slot_valid[k]);
        if (k > 0) begin : g_bubble
            // R7: advancing behind a stalled slot yields a bubble
            assert_bubble_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (stall_i[k-1] && !stall_i[k] && !flush_i[k]) |=> !slot_valid[k]);
        end
    end

    // R6: no verdict follows a cycle in which the memory slot is stalled
    assert_no_commit_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i[LAST] |=> !mismatch_o);
    // R8: no verdict follows a cycle in which the memory slot is flushed
    assert_no_commit_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i[LAST] |=> !mismatch_o);
    // R9: the sticky flag never drops outside reset
    assert_sticky_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> error_o);
    // R9: each pulse is accompanied by the sticky flag
    assert_pulse_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mismatch_o |-> error_o);
endmodule

bind conf_monitor conf_monitor_chk #(.NSLOT(NSLOT)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .flush_i    (flush_i),
    .slot_valid (slot_valid),
    .slot_op    (slot_op),
    .mismatch_o (mismatch_o),
    .error_o    (error_o)
);

// File: tb/sim_conf_monitor.sv
// Bench: directed scenarios for conf_monitor, one task each.
// Inputs are driven after falling edges and outputs are sampled there.
module sim_conf_monitor;
    localparam int XLEN = 32;
    localparam int NR   = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             fetch_valid_i;
    logic [15:0]      fetch_op_i;
    logic [2:0]       stall_i;
    logic [2:0]       flush_i;
    logic [NR*XLEN-1:0] rf_pre_i;
    logic [NR*XLEN-1:0] rf_post_i;
    logic             mismatch_o;
    logic             error_o;

    logic [XLEN-1:0] pre_r  [NR];
    logic [XLEN-1:0] post_r [NR];

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    // Pack the register views onto the ports.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            rf_pre_i[i*XLEN +: XLEN]  = pre_r[i];
            rf_post_i[i*XLEN +: XLEN] = post_r[i];
        end
    end

    conf_monitor u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_valid_i (fetch_valid_i),
        .fetch_op_i    (fetch_op_i),
        .stall_i       (stall_i),
        .flush_i       (flush_i),
        .rf_pre_i      (rf_pre_i),
        .rf_post_i     (rf_post_i),
        .mismatch_o    (mismatch_o),
        .error_o       (error_o)
    );

    function automatic logic [15:0] mk_add(input int a, input int b, input int d);
        return 16'h1800 | 16'((a & 7) << 6) | 16'((b & 7) << 3) | 16'(d & 7);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic chk_int(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_rf();
        for (int i = 0; i < NR; i++) begin
            pre_r[i]  = 32'(i * 3 + 1);
            post_r[i] = 32'(i * 3 + 1);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        fetch_valid_i = 1'b0;
        fetch_op_i = '0;
        stall_i = '0;
        flush_i = '0;
        tick();
        tick();
        rst_n = 1'b1;
    endtask

    // Present one opcode for a single acceptance edge; returns after that edge.
    task automatic issue(input logic [15:0] op);
        fetch_valid_i = 1'b1;
        fetch_op_i = op;
        tick();
        fetch_valid_i = 1'b0;
    endtask

    task automatic count_pulses(input int n, output int cnt);
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            tick();
            if (mismatch_o) cnt++;
        end
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        fetch_valid_i = 1'b0;
        fetch_op_i = '0;
        stall_i = '0;
        flush_i = '0;
        clear_rf();
        tick();
        chk("R1 mismatch in reset", mismatch_o, 1'b0);
        chk("R1 error in reset", error_o, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 mismatch after reset", mismatch_o, 1'b0);
        chk("R1 error after reset", error_o, 1'b0);
    endtask

    task automatic t_good_add();
        clear_rf();
        pre_r[1] = 32'd10; pre_r[2] = 32'd20; post_r[3] = 32'd30;
        issue(mk_add(1, 2, 3));
        tick(); tick(); tick();
        chk("R3 correct add not flagged", mismatch_o, 1'b0);
        chk("R3 correct add error flag", error_o, 1'b0);
    endtask

    task automatic t_bad_add_latency();
        clear_rf();
        pre_r[4] = 32'd5; pre_r[6] = 32'd7; post_r[0] = 32'd13;
        issue(mk_add(4, 6, 0));
        tick(); tick();
        chk("R5 no pulse before latency", mismatch_o, 1'b0);
        tick();
        chk("R5 pulse at latency", mismatch_o, 1'b1);
        chk("R9 error set with pulse", error_o, 1'b1);
        tick();
        chk("R5 pulse lasts one cycle", mismatch_o, 1'b0);
        chk("R9 error holds", error_o, 1'b1);
        do_reset();
        chk("R9 error cleared by reset", error_o, 1'b0);
    endtask

    task automatic t_field_select();
        int cnt;
        // Destination right, another after-state register wrong: no flag.
        clear_rf();
        pre_r[5] = 32'd100; pre_r[2] = 32'd1; post_r[7] = 32'd101;
        post_r[6] = 32'hDEAD_BEEF;
        issue(mk_add(5, 2, 7));
        count_pulses(5, cnt);
        chk_int("R3 only destination compared", cnt, 0);
        // Same source twice.
        clear_rf();
        pre_r[3] = 32'd21; post_r[1] = 32'd42;
        issue(mk_add(3, 3, 1));
        count_pulses(5, cnt);
        chk_int("R3 equal sources", cnt, 0);
        // Swapped destination field must be detected.
        clear_rf();
        pre_r[1] = 32'd8; pre_r[2] = 32'd9; post_r[6] = 32'd17; post_r[0] = 32'd99;
        issue(mk_add(1, 2, 0));
        count_pulses(5, cnt);
        chk_int("R3 wrong destination flagged", cnt, 1);
        do_reset();
    endtask

    task automatic t_wrap();
        int cnt;
        clear_rf();
        pre_r[7] = 32'hFFFF_FFFF; pre_r[5] = 32'd2; post_r[4] = 32'd1;
        issue(mk_add(7, 5, 4));
        count_pulses(5, cnt);
        chk_int("R4 wrapped sum accepted", cnt, 0);
        chk("R4 no error after wrap", error_o, 1'b0);
    endtask

    task automatic t_decode();
        int cnt;
        clear_rf();
        post_r[7] = 32'hBAD0_0000;
        post_r[0] = 32'hBAD0_0001;
        issue(16'h1A00 | 16'h01C7);
        count_pulses(5, cnt);
        chk_int("R2 near-miss opcode bit9 ignored", cnt, 0);
        issue(16'h0800 | 16'h0007);
        count_pulses(5, cnt);
        chk_int("R2 other opcode ignored", cnt, 0);
        chk("R2 error stays clear", error_o, 1'b0);
        issue(16'h19FF);
        count_pulses(5, cnt);
        chk_int("R2 0x19FF recognised as add", cnt, 1);
        do_reset();
    endtask

    task automatic t_invalid_fetch();
        int cnt;
        clear_rf();
        post_r[0] = 32'hFFFF_0000;
        fetch_valid_i = 1'b0;
        fetch_op_i = mk_add(1, 1, 0);
        tick();
        count_pulses(5, cnt);
        chk_int("R7 invalid fetch ignored", cnt, 0);
    endtask

    task automatic t_stall_mem();
        int cnt;
        clear_rf();
        post_r[2] = 32'h1234_5678;
        issue(mk_add(0, 1, 2));
        tick(); tick();
        stall_i[2] = 1'b1;
        tick();
        chk("R6 no check while memory slot stalled", mismatch_o, 1'b0);
        tick();
        chk("R6 still held", mismatch_o, 1'b0);
        stall_i[2] = 1'b0;
        tick();
        chk("R6 checked after release", mismatch_o, 1'b1);
        count_pulses(4, cnt);
        chk_int("R6 checked only once", cnt, 0);
        do_reset();
    endtask

    task automatic t_stall_id();
        int cnt;
        clear_rf();
        post_r[3] = 32'h0F0F_0F0F;
        issue(mk_add(1, 2, 3));
        stall_i[0] = 1'b1;
        tick();
        tick();
        stall_i[0] = 1'b0;
        count_pulses(8, cnt);
        chk_int("R7 stalled decode not duplicated", cnt, 1);
        do_reset();
    endtask

    task automatic t_flush();
        int cnt;
        clear_rf();
        post_r[5] = 32'hCAFE_0000;
        issue(mk_add(1, 2, 5));
        tick();
        flush_i[1] = 1'b1;
        tick();
        flush_i[1] = 1'b0;
        count_pulses(5, cnt);
        chk_int("R8 flushed in execute never checked", cnt, 0);
        issue(mk_add(1, 2, 5));
        tick(); tick();
        stall_i[2] = 1'b1;
        flush_i[2] = 1'b1;
        tick();
        stall_i[2] = 1'b0;
        flush_i[2] = 1'b0;
        chk("R8 no check on flush with stall", mismatch_o, 1'b0);
        count_pulses(5, cnt);
        chk_int("R8 flush wins over stall", cnt, 0);
        chk("R8 error stays clear", error_o, 1'b0);
    endtask

    task automatic t_back_to_back();
        clear_rf();
        post_r[6] = 32'h0;
        post_r[7] = 32'h0;
        pre_r[1] = 32'd1;
        fetch_valid_i = 1'b1;
        fetch_op_i = mk_add(1, 1, 6);
        tick();
        fetch_op_i = mk_add(1, 2, 7);
        tick();
        fetch_valid_i = 1'b0;
        tick();
        tick();
        chk("R5 first of pair", mismatch_o, 1'b1);
        tick();
        chk("R5 second of pair", mismatch_o, 1'b1);
        tick();
        chk("R5 pair ends", mismatch_o, 1'b0);
    endtask

    task automatic t_sticky();
        clear_rf();
        pre_r[1] = 32'd2; pre_r[2] = 32'd3; post_r[3] = 32'd5;
        issue(mk_add(1, 2, 3));
        tick(); tick(); tick();
        chk("R9 good add after error no pulse", mismatch_o, 1'b0);
        chk("R9 error still set", error_o, 1'b1);
        do_reset();
        chk("R9 reset clears error", error_o, 1'b0);
    endtask

    task automatic t_reset_in_flight();
        int cnt;
        clear_rf();
        post_r[4] = 32'hABCD_0000;
        issue(mk_add(1, 2, 4));
        rst_n = 1'b0;
        tick();
        tick();
        rst_n = 1'b1;
        count_pulses(6, cnt);
        chk_int("R10 in-flight add dropped by reset", cnt, 0);
        chk("R10 no error after reset", error_o, 1'b0);
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_good_add();
        t_bad_add_latency();
        t_field_select();
        t_wrap();
        t_decode();
        t_invalid_fetch();
        t_stall_mem();
        t_stall_id();
        t_flush();
        t_back_to_back();
        t_sticky();
        t_reset_in_flight();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule